// File: doc/BRIEF.md
# Fault Location Decision Unit

This block receives, one value per cycle, the final similarity scores of a test sample against each of M circuit modes, and decides which mode the sample belongs to. While the stream runs it keeps the largest score, the runner-up score, the position of the largest score, and the running total. When the value flagged as last arrives, it applies a two-stage acceptance rule and reports the winning mode index with one of three outcome codes.

Scores are unsigned fixed point with 15 fractional bits, so 1.0 is 32768. The primary test accepts when the top score is above the threshold `delta` and the gap to the runner-up is above the threshold `sigma`. If that test fails, a fallback test accepts when the top score is more than `lambda` times the mean score. That test uses no divider: it compares `max * count * 2^13` against `lambda * sum`, with `lambda` in unsigned Q3.13. A tie for the top score always gives an ambiguous result. The three thresholds sit in a small register bank that can be written at run time.

Control is a three-state machine:
- ST_IDLE means no stream is open.
- ST_COLLECT means a stream is being accumulated.
- ST_REPORT means the result was just registered and `res_valid` is high.

Transitions:
- ST_IDLE or ST_REPORT goes to ST_COLLECT on a value that is not last.
- Any state goes to ST_REPORT on a value flagged last.
- ST_COLLECT stays in ST_COLLECT on an idle cycle or on a value that is not last.
- ST_REPORT and ST_IDLE go to ST_IDLE on an idle cycle.

Top module: `fld_decide`

## Requirements
- R1: After reset the thresholds are `delta` = 26870 (0.82 in Q1.15), `sigma` = 7864 (0.24 in Q1.15) and `lambda` = 14336 (1.75 in Q3.13), and the result outputs are zero with `res_valid` low.
- R2: A cycle with `cfg_we` high writes `cfg_wdata` to `delta` when `cfg_addr` = 0, to `sigma` when it is 1, and to `lambda` when it is 2. Address 3 changes no threshold, and no threshold changes without `cfg_we`.
- R3: `res_valid` is high for exactly the one cycle that follows the clock edge at which a value with `sim_last` high is accepted, and is low at all other times.
- R4: `res_index` is the zero-based stream position of the largest score, taking the earliest position when several positions hold that score.
- R5: The outcome is UNIQUE (code 1) when the largest score is strictly above `delta` and the largest score minus the runner-up is strictly above `sigma`. Equality with either threshold fails this test.
- R6: When a new strictly larger score arrives, the previous largest becomes the runner-up, so the gap used in R5 is measured against it.
- R7: When R5 fails, the outcome is RATIO (code 2) when `max * M * 8192` is strictly greater than `lambda * sum`, where M is the stream length and sum is the total of all scores.
- R8: When neither test passes, the outcome is AMBIGUOUS (code 0). Code 3 never appears.
- R9: When two or more positions share the largest score, the outcome is AMBIGUOUS (code 0), whatever the thresholds.
- R10: A stream of length 1 sets `res_err` to 1 with outcome 0. A stream of length 2 or more clears `res_err`.
- R11: `res_index`, `res_outcome` and `res_err` hold their values until the next value flagged last is accepted.
- R12: A new stream may start in the cycle right after a last value, and no state from the previous stream affects its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sim_valid | input | 1 | A score is presented this cycle |
| sim_last | input | 1 | The presented score closes the stream |
| sim_value | input | VAL_W | Score, unsigned Q1.15 |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_addr | input | 2 | Threshold select: 0 delta, 1 sigma, 2 lambda |
| cfg_wdata | input | VAL_W | Threshold write data |
| res_valid | output | 1 | One-cycle result strobe |
| res_index | output | clog2(MAX_MODES+1) | Position of the largest score |
| res_outcome | output | 2 | 0 ambiguous, 1 unique, 2 ratio |
| res_err | output | 1 | Stream had fewer than two scores |

## Verification
The bench sweeps every length-3 stream over a value set that includes the default `delta` plus one, so the scores repeat and sit on thresholds. A design that updated the tie flag wrongly, or used non-strict compares, would then give the wrong outcome code. Directed streams place a new maximum just above an old one. A design that did not move the old maximum into the runner-up slot would report UNIQUE where the correct result is AMBIGUOUS. Back-to-back streams that reuse the previous maximum expose a tracker that keeps state across streams, because that design would report a false tie. Random streams with reprogrammed thresholds, including a write to the unused address, catch a wrong register decode and a wrong scale or strictness in the divider-free ratio test.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic [1:0] {
        OUT_AMBIG  = 2'd0,
        OUT_UNIQUE = 2'd1,
        OUT_RATIO  = 2'd2
    } outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_REPORT  = 2'd2
    } state_e;

    localparam logic [1:0] ADDR_DELTA  = 2'd0;
    localparam logic [1:0] ADDR_SIGMA  = 2'd1;
    localparam logic [1:0] ADDR_LAMBDA = 2'd2;

endpackage

// File: rtl/fld_thresh_regs.sv
module fld_thresh_regs #(
    parameter int VAL_W      = 16,
    parameter int DEF_DELTA  = 26870,
    parameter int DEF_SIGMA  = 7864,
    parameter int DEF_LAMBDA = 14336
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [VAL_W-1:0] wr_data,
    output logic [VAL_W-1:0] delta_o,
    output logic [VAL_W-1:0] sigma_o,
    output logic [VAL_W-1:0] lambda_o
);
    import fld_pkg::*;

    logic [VAL_W-1:0] delta_q, sigma_q, lambda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delta_q  <= VAL_W'(DEF_DELTA);
            sigma_q  <= VAL_W'(DEF_SIGMA);
            lambda_q <= VAL_W'(DEF_LAMBDA);
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_DELTA:  delta_q  <= wr_data;
                ADDR_SIGMA:  sigma_q  <= wr_data;
                ADDR_LAMBDA: lambda_q <= wr_data;
                default:     ;
            endcase
        end
    end

    assign delta_o  = delta_q;
    assign sigma_o  = sigma_q;
    assign lambda_o = lambda_q;

endmodule

// File: rtl/fld_tracker.sv
module fld_tracker #(
    parameter int VAL_W = 16,
    parameter int CNT_W = 6,
    parameter int SUM_W = VAL_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [VAL_W-1:0] in_value,
    output logic [VAL_W-1:0] nxt_max,
    output logic [VAL_W-1:0] nxt_sec,
    output logic [CNT_W-1:0] nxt_idx,
    output logic             nxt_tie,
    output logic [SUM_W-1:0] nxt_sum,
    output logic [CNT_W-1:0] nxt_cnt
);
    logic [VAL_W-1:0] max_q, sec_q;
    logic [CNT_W-1:0] idx_q, cnt_q;
    logic             tie_q;
    logic [SUM_W-1:0] sum_q;

    // Next-value path: includes the sample presented this cycle, so the
    // rule can be evaluated in the same cycle as the last sample.
    always_comb begin
        if (in_first) begin
            nxt_max = in_value;
            nxt_sec = '0;
            nxt_idx = '0;
            nxt_tie = 1'b0;
            nxt_sum = SUM_W'(in_value);
            nxt_cnt = CNT_W'(1);
        end else begin
            nxt_max = max_q;
            nxt_sec = sec_q;
            nxt_idx = idx_q;
            nxt_tie = tie_q;
            nxt_sum = sum_q + SUM_W'(in_value);
            nxt_cnt = cnt_q + CNT_W'(1);
            if (in_value > max_q) begin
                nxt_sec = max_q;
                nxt_max = in_value;
                nxt_idx = cnt_q;
                nxt_tie = 1'b0;
            end else if (in_value == max_q) begin
                nxt_sec = in_value;
                nxt_tie = 1'b1;
            end else if (in_value > sec_q) begin
                nxt_sec = in_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
            sec_q <= '0;
            idx_q <= '0;
            tie_q <= 1'b0;
            sum_q <= '0;
            cnt_q <= '0;
        end else if (in_valid) begin
            max_q <= nxt_max;
            sec_q <= nxt_sec;
            idx_q <= nxt_idx;
            tie_q <= nxt_tie;
            sum_q <= nxt_sum;
            cnt_q <= nxt_cnt;
        end
    end

endmodule

// File: rtl/fld_rule.sv
module fld_rule #(
    parameter int VAL_W    = 16,
    parameter int CNT_W    = 6,
    parameter int SUM_W    = VAL_W + CNT_W,
    parameter int LAM_FRAC = 13
) (
    input  logic [VAL_W-1:0] top_val,
    input  logic [VAL_W-1:0] run_val,
    input  logic             top_tie,
    input  logic [SUM_W-1:0] total,
    input  logic [CNT_W-1:0] count,
    input  logic [VAL_W-1:0] delta,
    input  logic [VAL_W-1:0] sigma,
    input  logic [VAL_W-1:0] lambda,
    output logic [1:0]       outcome,
    output logic             err
);
    import fld_pkg::*;

    localparam int PROD_W = VAL_W + SUM_W + 1;

    logic [VAL_W-1:0]  gap;
    logic [PROD_W-1:0] lhs, rhs;
    logic              pass_primary, pass_ratio;
    outcome_e          verdict;

    always_comb begin
        gap          = top_val - run_val;
        pass_primary = (top_val > delta) && (gap > sigma);
        lhs          = (PROD_W'(top_val) * PROD_W'(count)) << LAM_FRAC;
        rhs          = PROD_W'(lambda) * PROD_W'(total);
        pass_ratio   = lhs > rhs;
        err          = count < CNT_W'(2);
        if (err || top_tie)      verdict = OUT_AMBIG;
        else if (pass_primary)   verdict = OUT_UNIQUE;
        else if (pass_ratio)     verdict = OUT_RATIO;
        else                     verdict = OUT_AMBIG;
        outcome = verdict;
    end

endmodule

// File: rtl/fld_decide.sv
module fld_decide #(
    parameter int VAL_W      = 16,
    parameter int MAX_MODES  = 32,
    parameter int LAM_FRAC   = 13,
    parameter int DEF_DELTA  = 26870,
    parameter int DEF_SIGMA  = 7864,
    parameter int DEF_LAMBDA = 14336
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               sim_valid,
    input  logic                               sim_last,
    input  logic [VAL_W-1:0]                   sim_value,
    input  logic                               cfg_we,
    input  logic [1:0]                         cfg_addr,
    input  logic [VAL_W-1:0]                   cfg_wdata,
    output logic                               res_valid,
    output logic [$clog2(MAX_MODES+1)-1:0]     res_index,
    output logic [1:0]                         res_outcome,
    output logic                               res_err
);
    import fld_pkg::*;

    localparam int CNT_W = $clog2(MAX_MODES + 1);
    localparam int SUM_W = VAL_W + CNT_W;

    state_e           state_q, state_d;
    logic             take_last;
    logic [VAL_W-1:0] delta_q, sigma_q, lambda_q;
    logic [VAL_W-1:0] t_max, t_sec;
    logic [CNT_W-1:0] t_idx, t_cnt;
    logic             t_tie;
    logic [SUM_W-1:0] t_sum;
    logic [1:0]       rule_out;
    logic             rule_err;

    assign take_last = sim_valid && sim_last;

    fld_thresh_regs #(
        .VAL_W(VAL_W), .DEF_DELTA(DEF_DELTA),
        .DEF_SIGMA(DEF_SIGMA), .DEF_LAMBDA(DEF_LAMBDA)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .delta_o(delta_q), .sigma_o(sigma_q),
        .lambda_o(lambda_q)
    );

    fld_tracker #(.VAL_W(VAL_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) trk_i (
        .clk(clk), .rst_n(rst_n), .in_valid(sim_valid),
        .in_first(state_q != ST_COLLECT), .in_value(sim_value),
        .nxt_max(t_max), .nxt_sec(t_sec), .nxt_idx(t_idx),
        .nxt_tie(t_tie), .nxt_sum(t_sum), .nxt_cnt(t_cnt)
    );

    fld_rule #(
        .VAL_W(VAL_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .LAM_FRAC(LAM_FRAC)
    ) rule_i (
        .top_val(t_max), .run_val(t_sec), .top_tie(t_tie), .total(t_sum),
        .count(t_cnt), .delta(delta_q), .sigma(sigma_q), .lambda(lambda_q),
        .outcome(rule_out), .err(rule_err)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_REPORT: begin
                if (take_last)      state_d = ST_REPORT;
                else if (sim_valid) state_d = ST_COLLECT;
                else                state_d = ST_IDLE;
            end
            ST_COLLECT: begin
                if (take_last)      state_d = ST_REPORT;
                else                state_d = ST_COLLECT;
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_index   <= '0;
            res_outcome <= OUT_AMBIG;
            res_err     <= 1'b0;
        end else begin
            res_valid <= (state_d == ST_REPORT);
            if (take_last) begin
                res_index   <= t_idx;
                res_outcome <= rule_out;
                res_err     <= rule_err;
            end
        end
    end

endmodule

// File: rtl/fld_decide_chk.sv
module fld_decide_chk #(
    parameter int VAL_W     = 16,
    parameter int MAX_MODES = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sim_valid,
    input logic                           sim_last,
    input logic                           cfg_we,
    input logic                           res_valid,
    input logic [$clog2(MAX_MODES+1)-1:0] res_index,
    input logic [1:0]                     res_outcome,
    input logic                           res_err,
    input logic [VAL_W-1:0]               delta_q,
    input logic [VAL_W-1:0]               sigma_q,
    input logic [VAL_W-1:0]               lambda_q
);
    // R3
    res_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(sim_valid && sim_last));

    // R3
    res_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_valid && sim_last) |=> res_valid);

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sim_valid && sim_last) |=>
            ($stable(res_index) && $stable(res_outcome) && $stable(res_err)));

    // R10
    err_ambig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> (res_outcome == 2'd0));

    // R8
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_outcome != 2'd3);

    // R4
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (32'(res_index) < MAX_MODES));

    // R2
    thresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(delta_q) && $stable(sigma_q) && $stable(lambda_q)));

endmodule

bind fld_decide fld_decide_chk #(.VAL_W(VAL_W), .MAX_MODES(MAX_MODES)) chk_i (
    .clk(clk), .rst_n(rst_n), .sim_valid(sim_valid), .sim_last(sim_last),
    .cfg_we(cfg_we), .res_valid(res_valid), .res_index(res_index),
    .res_outcome(res_outcome), .res_err(res_err), .delta_q(delta_q),
    .sigma_q(sigma_q), .lambda_q(lambda_q)
);

// File: tb/fld_decide_tb_top.sv
module fld_decide_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VAL_W      = 16;
    localparam int MAX_MODES  = 32;
    localparam int CNT_W      = $clog2(MAX_MODES + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sim_valid, sim_last, cfg_we;
    logic [VAL_W-1:0] sim_value, cfg_wdata;
    logic [1:0]       cfg_addr;
    logic             res_valid, res_err;
    logic [CNT_W-1:0] res_index;
    logic [1:0]       res_outcome;

    int     n_checks = 0;
    int     n_fail   = 0;
    int     vals[MAX_MODES];
    longint m_delta  = 26870;
    longint m_sigma  = 7864;
    longint m_lambda = 14336;
    int     seed     = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    fld_decide #(.VAL_W(VAL_W), .MAX_MODES(MAX_MODES)) dut_i (
        .clk(clk), .rst_n(rst_n), .sim_valid(sim_valid), .sim_last(sim_last),
        .sim_value(sim_value), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_index(res_index),
        .res_outcome(res_outcome), .res_err(res_err)
    );

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h00FF_FFFF;
    endfunction

    // Independent reference: max (first position), tie, runner-up, total.
    task automatic model(input int n, output int ei, output int eo, output int ee);
        longint mx = -1, sec = 0, sum = 0;
        int ix = 0;
        bit tie = 0;
        for (int i = 0; i < n; i++) begin
            sum += vals[i];
            if (vals[i] > mx) begin mx = vals[i]; ix = i; end
        end
        for (int i = 0; i < n; i++) begin
            if (i != ix && vals[i] == mx) tie = 1;
            if (i != ix && vals[i] > sec) sec = vals[i];
        end
        ei = ix;
        ee = (n < 2) ? 1 : 0;
        if (n < 2 || tie)                            eo = 0;
        else if (mx > m_delta && mx - sec > m_sigma) eo = 1;
        else if (mx * n * 8192 > m_lambda * sum)     eo = 2;
        else                                         eo = 0;
    endtask

    task automatic cfg_write(input logic [1:0] a, input int d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = VAL_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 2'd0) m_delta = d;
        else if (a == 2'd1) m_sigma = d;
        else if (a == 2'd2) m_lambda = d;
    endtask

    task automatic drive_stream(input int n);
        for (int i = 0; i < n; i++) begin
            sim_valid = 1'b1;
            sim_last  = (i == n - 1);
            sim_value = VAL_W'(vals[i]);
            @(negedge clk);
        end
    endtask

    task automatic check_result(input int n, input string tag);
        int ei, eo, ee;
        model(n, ei, eo, ee);
        check(res_valid == 1'b1, {"R3 strobe ", tag}, res_valid, 1);
        check(res_index == CNT_W'(ei), {"R4 index ", tag}, res_index, ei);
        check(res_outcome == 2'(eo), {"R5/R7/R8/R9 outcome ", tag}, res_outcome, eo);
        check(res_err == 1'(ee), {"R10 err ", tag}, res_err, ee);
    endtask

    task automatic run_stream(input int n, input string tag);
        logic [CNT_W-1:0] hi;
        logic [1:0]       ho;
        drive_stream(n);
        sim_valid = 1'b0; sim_last = 1'b0;
        check_result(n, tag);
        hi = res_index; ho = res_outcome;
        @(negedge clk);
        check(res_valid == 1'b0, {"R3 single pulse ", tag}, res_valid, 0);
        check(res_index == hi && res_outcome == ho, {"R11 hold ", tag},
              {res_index, res_outcome}, {hi, ho});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int vset[5] = '{0, 8000, 20000, 26871, 32768};
        rst_n = 1'b0; sim_valid = 1'b0; sim_last = 1'b0; sim_value = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state of outputs
        check(res_valid == 1'b0 && res_outcome == 2'd0 && res_err == 1'b0
              && res_index == '0, "R1 reset outputs",
              {res_valid, res_outcome, res_err}, 0);

        // R1 defaults: delta boundary (equal fails, one above passes)
        vals[0] = 26870; vals[1] = 0;     run_stream(2, "R1 R5 max==delta");
        vals[0] = 26871; vals[1] = 0;     run_stream(2, "R1 R5 max>delta");
        // R5 gap equal to sigma fails primary
        vals[0] = 30000; vals[1] = 22136; run_stream(2, "R5 gap==sigma");
        vals[0] = 30000; vals[1] = 22135; run_stream(2, "R5 gap>sigma");
        // R6 new maximum pushes old into runner-up
        vals[0] = 25000; vals[1] = 30000; vals[2] = 1000;
        run_stream(3, "R6 displaced max");
        // R9 tie at the top, ratio would pass
        for (int i = 0; i < 8; i++) vals[i] = 0;
        vals[0] = 30000; vals[1] = 30000; run_stream(8, "R9 tie");
        vals[2] = 32000;                  run_stream(8, "R9 tie cleared");
        // R7 ratio boundary: max*M*8192 == lambda*sum with lambda 2.0
        cfg_write(2'd0, 32768);
        cfg_write(2'd2, 16384);
        vals[0] = 20000; vals[1] = 0;     run_stream(2, "R7 ratio equal");
        vals[0] = 20000; vals[1] = 0; vals[2] = 0; run_stream(3, "R7 ratio above");
        // R2 unused address changes nothing
        cfg_write(2'd3, 0);
        vals[0] = 20000; vals[1] = 0;     run_stream(2, "R2 addr3 ignored");
        cfg_write(2'd0, 26870); cfg_write(2'd2, 14336);
        // R10 single-value stream
        vals[0] = 32768;                  run_stream(1, "R10 length 1");

        // R12 back-to-back streams, second reuses first maximum
        vals[0] = 1000; vals[1] = 31000;
        drive_stream(2);
        check_result(2, "R12 stream A");
        vals[0] = 31000; vals[1] = 2000; vals[2] = 1000;
        drive_stream(3);
        sim_valid = 1'b0; sim_last = 1'b0;
        check_result(3, "R12 stream B");
        @(negedge clk);

        // Sweep: all length-3 streams over a small value set
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                for (int c = 0; c < 5; c++) begin
                    vals[0] = vset[a]; vals[1] = vset[b]; vals[2] = vset[c];
                    run_stream(3, "sweep3");
                end

        // Random streams with reprogrammed thresholds
        for (int s = 0; s < 200; s++) begin
            int n;
            if (s % 25 == 0) begin
                cfg_write(2'd0, rnd() % 32769);
                cfg_write(2'd1, rnd() % 16384);
                cfg_write(2'd2, 8192 + rnd() % 16384);
                cfg_write(2'd3, rnd() % 65536);
            end
            n = 1 + rnd() % 12;
            for (int i = 0; i < n; i++)
                vals[i] = (rnd() % 4 == 0) ? vset[rnd() % 5] : rnd() % 32769;
            run_stream(n, "R2 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule